// File: doc/BRIEF.md
# Port-Enable Control Register File

This block is the control and status register bank of a serial-link bus master. A simple 32-bit read/write bus reaches it, addressed by word (the byte offset with its two low bits removed). Two 32-bit port-enable masks live in the bank. Each mask can be replaced outright, or changed by writing to an alias word that ORs bits in or knocks bits out, so software never needs a read-modify-write. Bits are numbered big-endian: bit 0 is the most significant bit of the data word.

The bank also has a version word that comes out of reset with a fixed value, and a port-reset word that takes writes but never stores them. A command word resets the whole bank when either of its two top bits is set. Every other word in the 1 KiB window is plain storage. Reads return one clock after the strobe. Accesses outside the window do nothing, and reads there return zero.

Top module: `pecr_regfile`

## Requirements
- R1: `bus_waddr` carries the word address, which is the byte offset shifted right by two. The implemented window is word addresses 0 to 255, which is byte offsets 0x000 to 0x3FF.
- R2: `bus_rvalid` is high in exactly the cycle after a cycle with `bus_rd` high. `bus_rdata` then holds the word that was addressed. After reset both are zero.
- R3: A write to byte offset 0x010 replaces enable mask 0. A write to 0x014 replaces enable mask 1.
- R4: A write to 0x018 or 0x01C ORs the data into mask 0 or mask 1. A read of either alias word returns zero.
- R5: A write to 0x020 or 0x024 clears, in mask 0 or mask 1, every bit that is set in the data. A read of either alias word returns zero.
- R6: Writes to the port-reset word at 0x0D0 are discarded, and it always reads zero.
- R7: A write to the command word at 0x1D0 whose data has big-endian bit 0 or bit 1 set resets every word to its reset value on the following clock edge. These are LSB-numbered bits 31 and 30, so the values 0x80000000 and 0x40000000 both trigger it. Other data values have no effect, and the command word reads zero.
- R8: After reset the version word at 0x074 reads 0xE0050101: version 0xE0 in bits 0–7, bridge count 0x05 in bits 8–15 and port count 0x01 in bits 16–23 (big-endian numbering). Every other word reads zero.
- R9: A write outside the window changes nothing, and a read outside it returns zero.
- R10: A write to any other in-window word, including mode at 0x000, delay at 0x004, error control at 0x2E0 and the version word, is stored whole and read back unchanged.
- R11: A write that arrives in the cycle in which a command reset takes effect is lost, because the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 14 | Word address (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The assertions check on every cycle that the mask updates follow the set, clear and replace rules. They also check the one-cycle read handshake, the zero returned for reads outside the window or of the discarded word, and that a pending command clears both masks. Only the bench scenarios can show that the version word comes back after a command reset, that a command value without the two top bits leaves stored words intact, and that a write in the reset cycle is lost. The same holds for storage words outside the masks, whose final contents the bench follows through a reference model of the whole map.

// File: rtl/pecr_pkg.sv
package pecr_pkg;

   // Write operation selected by the address decoder
   typedef enum logic [2:0] {
      OP_NONE,
      OP_STORE,
      OP_LOAD,
      OP_SET,
      OP_CLR,
      OP_CMD,
      OP_DROP
   } pecr_op_e;

   localparam int unsigned PECR_MASKS    = 2;
   localparam int unsigned PECR_OFS_MASK = 'h010;
   localparam int unsigned PECR_OFS_SET  = 'h018;
   localparam int unsigned PECR_OFS_CLR  = 'h020;
   localparam int unsigned PECR_OFS_VER  = 'h074;
   localparam int unsigned PECR_OFS_PRST = 'h0D0;
   localparam int unsigned PECR_OFS_CMD  = 'h1D0;
   localparam logic [31:0] PECR_VER_INIT = 32'hE005_0101;

endpackage

// File: rtl/pecr_decode.sv
module pecr_decode
   import pecr_pkg::*;
#(
   parameter int unsigned WADDR_W  = 14,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned NMASK    = 2,
   parameter int unsigned MASK_IDX = 4,
   parameter int unsigned SET_IDX  = 6,
   parameter int unsigned CLR_IDX  = 8,
   parameter int unsigned PRST_IDX = 52,
   parameter int unsigned CMD_IDX  = 116,
   localparam int unsigned SEL_W   = (NMASK > 1) ? $clog2(NMASK) : 1
) (
   input  logic [WADDR_W-1:0] waddr,
   output logic               in_range,
   output logic [IDX_W-1:0]   idx,
   output pecr_op_e           op,
   output logic [SEL_W-1:0]   sel
);

   assign idx = waddr[IDX_W-1:0];

   generate
      if (WADDR_W > IDX_W) begin : g_hi
         assign in_range = (waddr[WADDR_W-1:IDX_W] == '0);
      end else begin : g_full
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      op  = OP_STORE;
      sel = '0;
      for (int k = 0; k < NMASK; k++) begin
         if (idx == IDX_W'(MASK_IDX + k)) begin
            op  = OP_LOAD;
            sel = SEL_W'(k);
         end
         if (idx == IDX_W'(SET_IDX + k)) begin
            op  = OP_SET;
            sel = SEL_W'(k);
         end
         if (idx == IDX_W'(CLR_IDX + k)) begin
            op  = OP_CLR;
            sel = SEL_W'(k);
         end
      end
      if (idx == IDX_W'(PRST_IDX)) op = OP_DROP;
      if (idx == IDX_W'(CMD_IDX))  op = OP_CMD;
      if (!in_range)               op = OP_NONE;
   end

endmodule

// File: rtl/pecr_mask.sv
module pecr_mask #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         load,
   input  logic         set,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (soft_clr) q <= '0;
      else if (load)     q <= din;
      else if (set)      q <= q | din;
      else if (clr)      q <= q & ~din;
   end

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !soft_clr) |=> (q == $past(din)));

   // R4
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !soft_clr) |=> (q == ($past(q) | $past(din))));

   // R5
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !soft_clr) |=> (q == ($past(q) & ~$past(din))));

   // R7
   mask_sclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (q == '0));

endmodule

// File: rtl/pecr_store.sv
module pecr_store #(
   parameter int unsigned W       = 32,
   parameter int unsigned WORDS   = 256,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned RST_IDX = 29,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);

   logic [WORDS*W-1:0] flat;

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         localparam logic [W-1:0] INIT = (w == RST_IDX) ? RST_VAL : '0;
         logic [W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            word_q <= INIT;
            else if (soft_clr)                     word_q <= INIT;
            else if (we && widx == IDX_W'(w))      word_q <= wdata;
         end
         assign flat[w*W +: W] = word_q;
      end
   endgenerate

   assign rdata = flat[ridx*W +: W];

endmodule

// File: rtl/pecr_regfile.sv
module pecr_regfile
   import pecr_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WORDS    = 256,
   parameter int unsigned WADDR_W  = 14,
   parameter int unsigned NMASK    = PECR_MASKS,
   parameter int unsigned OFS_MASK = PECR_OFS_MASK,
   parameter int unsigned OFS_SET  = PECR_OFS_SET,
   parameter int unsigned OFS_CLR  = PECR_OFS_CLR,
   parameter int unsigned OFS_VER  = PECR_OFS_VER,
   parameter int unsigned OFS_PRST = PECR_OFS_PRST,
   parameter int unsigned OFS_CMD  = PECR_OFS_CMD,
   parameter logic [DATA_W-1:0] VER_INIT = DATA_W'(PECR_VER_INIT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [WADDR_W-1:0] bus_waddr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_rvalid
);

   localparam int unsigned IDX_W    = $clog2(WORDS);
   localparam int unsigned SEL_W    = (NMASK > 1) ? $clog2(NMASK) : 1;
   localparam int unsigned MASK_IDX = OFS_MASK >> 2;
   localparam int unsigned SET_IDX  = OFS_SET >> 2;
   localparam int unsigned CLR_IDX  = OFS_CLR >> 2;
   localparam int unsigned VER_IDX  = OFS_VER >> 2;
   localparam int unsigned PRST_IDX = OFS_PRST >> 2;
   localparam int unsigned CMD_IDX  = OFS_CMD >> 2;

   // Elaboration-time parameter checks
   generate
      if ((WORDS & (WORDS - 1)) != 0 || WORDS < 2) begin : g_bad_words
         $error("WORDS must be a power of two");
      end
      if (WADDR_W < IDX_W) begin : g_bad_addr
         $error("WADDR_W too narrow for WORDS");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must hold the two command bits");
      end
      if (CMD_IDX >= WORDS || PRST_IDX >= WORDS || VER_IDX >= WORDS) begin : g_bad_ofs
         $error("register offset beyond the window");
      end
      if (MASK_IDX + NMASK > SET_IDX || SET_IDX + NMASK > CLR_IDX) begin : g_bad_alias
         $error("mask and alias words overlap");
      end
   endgenerate

   logic               in_range;
   logic [IDX_W-1:0]   idx;
   pecr_op_e           op;
   logic [SEL_W-1:0]   sel;

   pecr_decode #(
      .WADDR_W (WADDR_W),
      .IDX_W   (IDX_W),
      .NMASK   (NMASK),
      .MASK_IDX(MASK_IDX),
      .SET_IDX (SET_IDX),
      .CLR_IDX (CLR_IDX),
      .PRST_IDX(PRST_IDX),
      .CMD_IDX (CMD_IDX)
   ) i_decode (
      .waddr   (bus_waddr),
      .in_range(in_range),
      .idx     (idx),
      .op      (op),
      .sel     (sel)
   );

   // Command reset: captured on the write edge, applied on the next one
   logic soft_pend_q;
   logic wr_eff;
   logic cmd_hit;

   assign wr_eff  = bus_wr && !soft_pend_q;
   assign cmd_hit = wr_eff && (op == OP_CMD) &&
                    (bus_wdata[DATA_W-1] || bus_wdata[DATA_W-2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_pend_q <= 1'b0;
      else        soft_pend_q <= cmd_hit;
   end

   // Port-enable masks
   logic [NMASK*DATA_W-1:0] mask_flat;

   generate
      for (genvar k = 0; k < NMASK; k++) begin : g_mask
         logic hit;
         assign hit = wr_eff && (sel == SEL_W'(k));
         pecr_mask #(.W(DATA_W)) i_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .soft_clr(soft_pend_q),
            .load    (hit && op == OP_LOAD),
            .set     (hit && op == OP_SET),
            .clr     (hit && op == OP_CLR),
            .din     (bus_wdata),
            .q       (mask_flat[k*DATA_W +: DATA_W])
         );
      end
   endgenerate

   // Plain storage words
   logic [DATA_W-1:0] store_rd;

   pecr_store #(
      .W      (DATA_W),
      .WORDS  (WORDS),
      .IDX_W  (IDX_W),
      .RST_IDX(VER_IDX),
      .RST_VAL(VER_INIT)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_clr(soft_pend_q),
      .we      (wr_eff && op == OP_STORE),
      .widx    (idx),
      .wdata   (bus_wdata),
      .ridx    (idx),
      .rdata   (store_rd)
   );

   // Read path
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      if (!in_range)          rd_word = '0;
      else if (op == OP_LOAD) rd_word = mask_flat[sel*DATA_W +: DATA_W];
      else                    rd_word = store_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_word;
      end
   end

   // R2
   rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   // R2
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);

   // R9
   oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_range) |=> (bus_rdata == '0));

   // R6
   prst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && op == OP_DROP) |=> (bus_rdata == '0));

   // R7
   cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && op == OP_CMD) |=> (bus_rdata == '0));

endmodule

// File: tb/test_pecr_regfile.sv
module test_pecr_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [13:0] bus_waddr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #2 clk = ~clk;  // 250 MHz

   pecr_regfile i_pecr_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_waddr (bus_waddr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_rvalid(bus_rvalid)
   );

   // Reference model of the register map
   logic [31:0] mdl [256];
   bit          pend = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic mdl_reset();
      for (int i = 0; i < 256; i++) mdl[i] = 32'h0;
      mdl['h074 >> 2] = 32'hE005_0101;
   endtask

   task automatic fail_line(string req, logic [31:0] act, logic [31:0] exp);
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
   endtask

   task automatic wr(int ofs, logic [31:0] d);
      @(negedge clk);
      bus_rd    = 1'b0;
      bus_wr    = 1'b1;
      bus_waddr = 14'(ofs >> 2);
      bus_wdata = d;
      if (pend) begin
         mdl_reset();
         pend = 0;
      end else if (ofs < 'h400) begin
         int ix = ofs >> 2;
         case (ix)
            4, 5:    mdl[ix] = d;
            6, 7:    mdl[ix-2] = mdl[ix-2] | d;
            8, 9:    mdl[ix-4] = mdl[ix-4] & ~d;
            52:      ;
            116:     if (d[31] || d[30]) pend = 1;
            default: mdl[ix] = d;
         endcase
      end
   endtask

   task automatic rd(int ofs, string req);
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_rd    = 1'b1;
      bus_waddr = 14'(ofs >> 2);
      exp_q.push_back((ofs < 'h400) ? mdl[ofs >> 2] : 32'h0);
      tag_q.push_back(req);
      if (pend) begin
         mdl_reset();
         pend = 0;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_rd = 1'b0;
         bus_wr = 1'b0;
         if (pend) begin
            mdl_reset();
            pend = 0;
         end
      end
   endtask

   // Monitor: compare results as they appear
   logic last_rd = 1'b0;
   always @(posedge clk) last_rd <= bus_rd;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rvalid !== last_rd) begin
            tests++;
            fail_line("R2 rvalid timing", 32'(bus_rvalid), 32'(last_rd));
         end
         if (bus_rvalid) begin
            tests++;
            if (exp_q.size() == 0) begin
               fail_line("R2 unexpected read data", bus_rdata, 32'h0);
            end else begin
               logic [31:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (bus_rdata !== e) fail_line(t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      mdl_reset();
      repeat (3) @(negedge clk);
      // R2 R8: outputs idle during reset
      tests++;
      if (bus_rvalid !== 1'b0 || bus_rdata !== 32'h0)
         fail_line("R2 reset outputs", bus_rdata, 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R8: reset values, version fields
      rd('h074, "R8 version reset");
      rd('h000, "R8 mode reset zero");
      rd('h010, "R8 mask0 reset zero");
      rd('h2E0, "R8 errctl reset zero");

      // R10: plain storage, R1 word mapping
      wr('h000, 32'hA5A5_5A5A);
      wr('h004, 32'h1234_0000);
      wr('h2E0, 32'h0007_8001);
      wr('h3FC, 32'hDEAD_BEEF);
      rd('h000, "R10 mode readback");
      rd('h004, "R10 delay readback");
      rd('h2E0, "R10 errctl readback");
      rd('h3FC, "R1 last word in window");
      wr('h074, 32'h1234_5678);
      rd('h074, "R10 version writable");

      // R3 R4 R5: mask 0
      wr('h010, 32'hF0F0_0000);
      rd('h010, "R3 mask0 load");
      wr('h018, 32'h0000_000F);
      rd('h010, "R4 mask0 set");
      rd('h018, "R4 set alias reads zero");
      wr('h020, 32'hF000_0001);
      rd('h010, "R5 mask0 clear");
      rd('h020, "R5 clear alias reads zero");

      // R3 R4 R5: mask 1, independent of mask 0
      wr('h014, 32'h0000_FFFF);
      wr('h01C, 32'h8000_0000);
      wr('h024, 32'h0000_00F0);
      rd('h014, "R5 mask1 set then clear");
      rd('h01C, "R4 mask1 alias zero");
      rd('h024, "R5 mask1 alias zero");
      rd('h010, "R3 mask0 unaffected by mask1");

      // R6: port-reset word discards writes
      wr('h0D0, 32'hFFFF_FFFF);
      rd('h0D0, "R6 port reset reads zero");

      // R7: command value without top bits does nothing
      wr('h1D0, 32'h3FFF_FFFF);
      idle(1);
      rd('h1D0, "R7 command reads zero");
      rd('h000, "R7 no reset on low bits");
      rd('h010, "R7 mask kept on low bits");

      // R9: out-of-window accesses
      wr('h400, 32'h5555_5555);
      wr('hFFFC, 32'h6666_6666);
      rd('h400, "R9 read beyond window");
      rd('hFFFC, "R9 read top of space");
      rd('h000, "R9 window untouched");

      // R2: back-to-back reads
      rd('h004, "R2 pipelined read a");
      rd('h2E0, "R2 pipelined read b");
      rd('h014, "R2 pipelined read c");
      idle(1);

      // R7: big-endian bit 0 resets everything
      wr('h1D0, 32'h8000_0000);
      idle(1);
      rd('h074, "R7 version restored");
      rd('h000, "R7 mode cleared");
      rd('h010, "R7 mask0 cleared");
      rd('h014, "R7 mask1 cleared");

      // R11: write in the reset cycle is lost; R7 big-endian bit 1
      wr('h000, 32'h0000_1111);
      wr('h010, 32'h0000_2222);
      wr('h1D0, 32'h4000_0000);
      wr('h004, 32'h0000_3333);
      idle(1);
      rd('h004, "R11 write in reset cycle lost");
      rd('h000, "R7 error-reset clears mode");
      rd('h010, "R7 error-reset clears mask0");
      rd('h074, "R8 version after error reset");

      idle(4);
      tests++;
      if (exp_q.size() != 0)
         fail_line("R2 reads left unanswered", 32'(exp_q.size()), 32'h0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule